// File: doc/BRIEF.md
# Prescaled Dual Down-Counter Timer

This block holds two independent 32-bit down-counting timers that share one prescaler. The prescaler counts clock cycles and, each time it passes zero, issues a single-cycle tick that steps every enabled timer down by one. A timer that is at zero when a tick arrives has underflowed. It then pulses its own interrupt line for one clock and either reloads from its reload value or stops.

Software drives the block through a simple 32-bit register bus: a write strobe, a byte address and write data. Read data follows the address combinationally in the same cycle. Each timer has a counter register, a reload register and a small control word: an enable bit, a reload-or-stop bit and a write-only load bit. The prescaler has a counter register and a reload register. Timer 1's interrupt feeds interrupt source 8 and timer 2's feeds interrupt source 9.

Top module: `dual_down_timer`

## Requirements
- R1: Byte offsets 0x40/0x44/0x48 are timer 1 counter/reload/control, 0x50/0x54/0x58 are the same for timer 2, 0x60 is the prescaler counter and 0x64 the prescaler reload. Counter and reload registers accept and read back full 32-bit values.
- R2: Any other offset reads as zero, and a write to it changes no register.
- R3: A control register keeps only bit 0 (enable) and bit 1 (reload mode). Reads return those two bits in place, with every other bit zero, bit 2 included.
- R4: While at least one timer is enabled, the prescaler counts down by one per clock. At zero it reloads from the prescaler reload register and emits a tick, so ticks come every reload+1 clocks. With both timers disabled it holds its value.
- R5: An enabled timer counts down by one on each tick that finds it above zero. A disabled timer holds its count.
- R6: A tick that finds an enabled timer at zero makes that timer's interrupt high for exactly the next clock. irqOut bit 0 is timer 1 (interrupt source 8) and bit 1 is timer 2 (interrupt source 9).
- R7: With control bit 1 set, an underflow reloads the counter from its reload register, and counting goes on.
- R8: With control bit 1 clear, an underflow leaves the counter at zero and the hardware clears the enable bit, so the timer raises no further interrupts.
- R9: Writing a control word with bit 2 set copies the reload value into the counter. With bit 2 clear, the write leaves the counter unchanged.
- R10: A load request or a direct counter write in the same cycle as a tick sets the counter to the written or reload value, and the tick does not decrement it.
- R11: After reset every register reads zero and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W (8) | Byte address of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data for busAddr, combinational |
| irqOut | output | 2 | One-clock underflow strobes, bit 0 timer 1, bit 1 timer 2 |

## Verification
The bench targets four cases:
- A load or counter write landing on a tick edge. A design with the priority wrong would show the written value minus one.
- Stop mode. A design that failed to clear enable would keep firing on every tick at zero.
- A reload value of zero in reload mode, which gives an interrupt on every tick, including back-to-back pulses. A design that assumed pulses are isolated would miss these.
- The prescaler with both timers off. A design that kept it running would shift every later tick.

Random writes with small values force frequent collisions among these cases. The bench also writes unused offsets and control words with bit 2 set, then reads everything back, to catch stray decode and a stored load bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR    = 2;
  localparam int TMR_BASE   = 'h40;
  localparam int TMR_STRIDE = 'h10;
  localparam int OFS_CNT    = 'h0;
  localparam int OFS_REL    = 'h4;
  localparam int OFS_CTL    = 'h8;
  localparam int PRE_CNT    = 'h60;
  localparam int PRE_REL    = 'h64;
  localparam int CTL_EN     = 0;
  localparam int CTL_RL     = 1;
  localparam int CTL_LD     = 2;

  // control -> datapath, one per timer
  typedef struct packed {
    logic cntWr;       // bus writes the counter directly
    logic ldReq;       // control write with load bit set
    logic step;        // prescaler tick reaching an enabled timer
    logic autoReload;  // reload at underflow instead of stopping
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busWe,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                busWdata,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]   cntVal,
  input  logic [NUM_TMR-1:0]               stopHit,
  output tmrStrobe_t [NUM_TMR-1:0]         strb,
  output logic [NUM_TMR-1:0][DATA_W-1:0]   relVal,
  output logic [DATA_W-1:0]                busRdata
);
  localparam logic [ADDR_W-1:0] PRE_CNT_A = ADDR_W'(PRE_CNT);
  localparam logic [ADDR_W-1:0] PRE_REL_A = ADDR_W'(PRE_REL);

  function automatic logic [ADDR_W-1:0] regAddr(input int t, input int ofs);
    return ADDR_W'(TMR_BASE + TMR_STRIDE * t + ofs);
  endfunction

  logic [DATA_W-1:0]  preCnt, preRel;
  logic [NUM_TMR-1:0] enQ, rlQ;
  logic               run, tick, preWr;

  assign preWr = busWe && (busAddr == PRE_CNT_A);
  assign run   = |enQ;
  assign tick  = run && (preCnt == '0) && !preWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      preRel <= '0;
    end else begin
      if (preWr)                            preCnt <= busWdata;
      else if (run && preCnt == '0)         preCnt <= preRel;
      else if (run)                         preCnt <= preCnt - 1'b1;
      if (busWe && busAddr == PRE_REL_A)    preRel <= busWdata;
    end
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic selCnt, selRel, selCtl;
    assign selCnt = busWe && (busAddr == regAddr(i, OFS_CNT));
    assign selRel = busWe && (busAddr == regAddr(i, OFS_REL));
    assign selCtl = busWe && (busAddr == regAddr(i, OFS_CTL));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[i]    <= 1'b0;
        rlQ[i]    <= 1'b0;
        relVal[i] <= '0;
      end else begin
        if (selCtl) begin
          enQ[i] <= busWdata[CTL_EN];
          rlQ[i] <= busWdata[CTL_RL];
        end else if (stopHit[i]) begin
          enQ[i] <= 1'b0;
        end
        if (selRel) relVal[i] <= busWdata;
      end
    end

    assign strb[i].cntWr      = selCnt;
    assign strb[i].ldReq      = selCtl && busWdata[CTL_LD];
    assign strb[i].step       = tick && enQ[i];
    assign strb[i].autoReload = rlQ[i];

    // R8: an underflow in stop mode turns the timer off
    a_r8_stop_disables: assert property (@(posedge clk) disable iff (!rstN)
      (stopHit[i] && !selCtl) |=> !enQ[i]);
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == PRE_CNT_A) busRdata = preCnt;
    if (busAddr == PRE_REL_A) busRdata = preRel;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (busAddr == regAddr(t, OFS_CNT)) busRdata = cntVal[t];
      if (busAddr == regAddr(t, OFS_REL)) busRdata = relVal[t];
      if (busAddr == regAddr(t, OFS_CTL)) busRdata = DATA_W'({rlQ[t], enQ[t]});
    end
  end

  // R4: the prescaler holds while every timer is off
  a_r4_prescaler_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !preWr) |=> $stable(preCnt));
  // R4: a tick is followed by the reload value in the prescaler
  a_r4_tick_reloads: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (preCnt == $past(preRel)));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  tmrStrobe_t [NUM_TMR-1:0]         strb,
  input  logic [DATA_W-1:0]                busWdata,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]   relVal,
  output logic [NUM_TMR-1:0][DATA_W-1:0]   cntVal,
  output logic [NUM_TMR-1:0]               stopHit,
  output logic [NUM_TMR-1:0]               irqOut
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_cnt
    logic busOwns, atZero, underflow;
    assign busOwns   = strb[i].cntWr || strb[i].ldReq;
    assign atZero    = (cntVal[i] == '0);
    assign underflow = strb[i].step && atZero && !busOwns;
    assign stopHit[i] = underflow && !strb[i].autoReload;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntVal[i] <= '0;
        irqOut[i] <= 1'b0;
      end else begin
        irqOut[i] <= underflow;
        if (strb[i].cntWr)                   cntVal[i] <= busWdata;
        else if (strb[i].ldReq)              cntVal[i] <= relVal[i];
        else if (underflow)                  cntVal[i] <= strb[i].autoReload ? relVal[i] : '0;
        else if (strb[i].step)               cntVal[i] <= cntVal[i] - 1'b1;
      end
    end

    // R6: a pulse only follows a tick that met a zero count
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[i] |-> $past(strb[i].step && cntVal[i] == '0));
    // R5: with no tick and no bus access the count holds
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
      (!strb[i].step && !strb[i].cntWr && !strb[i].ldReq) |=> $stable(cntVal[i]));
    // R10: a load request wins over a tick
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].ldReq && !strb[i].cntWr) |=> (cntVal[i] == $past(relVal[i])));
    // R8: stop mode leaves the counter at zero
    a_r8_stop_at_zero: assert property (@(posedge clk) disable iff (!rstN)
      stopHit[i] |=> (cntVal[i] == '0));
  end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [1:0]        irqOut
);
  tmrStrobe_t [NUM_TMR-1:0]       strb;
  logic [NUM_TMR-1:0][DATA_W-1:0] cntVal, relVal;
  logic [NUM_TMR-1:0]             stopHit;

  tmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .cntVal(cntVal), .stopHit(stopHit),
    .strb(strb), .relVal(relVal), .busRdata(busRdata)
  );

  tmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .relVal(relVal), .cntVal(cntVal), .stopHit(stopHit), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_dual_down_timer.sv
`timescale 1ns/1ps
module tb_dual_down_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_down_timer dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // reference model state
  logic [31:0] mCnt[2], mRel[2];
  logic        mEn[2], mRl[2], mIrq[2];
  logic [31:0] mPre, mPreRel;

  task automatic modelReset();
    for (int t = 0; t < 2; t++) begin
      mCnt[t] = 0; mRel[t] = 0; mEn[t] = 0; mRl[t] = 0; mIrq[t] = 0;
    end
    mPre = 0; mPreRel = 0;
  endtask

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    logic [31:0] r = 0;
    if (a == 8'h60) r = mPre;
    if (a == 8'h64) r = mPreRel;
    for (int t = 0; t < 2; t++) begin
      if (a == 8'h40 + 8'(16 * t)) r = mCnt[t];
      if (a == 8'h44 + 8'(16 * t)) r = mRel[t];
      if (a == 8'h48 + 8'(16 * t)) r = {30'd0, mRl[t], mEn[t]};
    end
    return r;
  endfunction

  task automatic modelStep(input logic we, input logic [7:0] a, input logic [31:0] d);
    logic run, tick, preWr;
    logic [7:0] b;
    run   = mEn[0] | mEn[1];
    preWr = we && a == 8'h60;
    tick  = run && mPre == 0 && !preWr;
    for (int t = 0; t < 2; t++) begin
      b = 8'h40 + 8'(16 * t);
      mIrq[t] = 0;
      if (we && a == b) mCnt[t] = d;
      else if (we && a == b + 8'h8 && d[2]) mCnt[t] = mRel[t];
      else if (tick && mEn[t]) begin
        if (mCnt[t] == 0) begin
          mIrq[t] = 1;
          if (mRl[t]) mCnt[t] = mRel[t];
          else mEn[t] = 0;
        end else mCnt[t] = mCnt[t] - 1;
      end
      if (we && a == b + 8'h8) begin mEn[t] = d[0]; mRl[t] = d[1]; end
      if (we && a == b + 8'h4) mRel[t] = d;
    end
    if (preWr) mPre = d;
    else if (run) mPre = (mPre == 0) ? mPreRel : mPre - 1;
    if (we && a == 8'h64) mPreRel = d;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, step model, check irq at next negedge
  task automatic doCycle(input logic we, input logic [7:0] a, input logic [31:0] d);
    busWe = we; busAddr = a; busWdata = d;
    modelStep(we, a, d);
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
    chk("R6 irq vs model", {30'd0, irqOut}, {30'd0, mIrq[1], mIrq[0]});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) doCycle(1'b0, 8'h00, 32'h0);
  endtask

  task automatic readReg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busWe = 1'b0; busAddr = a;
    #1;
    chk(tag, busRdata, exp);
    chk({tag, " vs model"}, busRdata, modelRead(a));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulses, backToBack;
    logic [7:0] addrs[12];
    logic [7:0] a;
    logic [31:0] d;
    addrs = '{8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h58, 8'h5C,
              8'h60, 8'h64, 8'h68, 8'hA0};
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    readReg(8'h40, 0, "R11 cnt1");  readReg(8'h44, 0, "R11 rel1");
    readReg(8'h48, 0, "R11 ctl1");  readReg(8'h50, 0, "R11 cnt2");
    readReg(8'h54, 0, "R11 rel2");  readReg(8'h58, 0, "R11 ctl2");
    readReg(8'h60, 0, "R11 pre");   readReg(8'h64, 0, "R11 prerel");
    chk("R11 irq", {30'd0, irqOut}, 0);

    // R2 unused offsets
    doCycle(1, 8'h4C, 32'hFFFF_FFFF);
    doCycle(1, 8'h5C, 32'hFFFF_FFFF);
    readReg(8'h4C, 0, "R2 unused 4C");
    readReg(8'h5C, 0, "R2 unused 5C");
    readReg(8'h40, 0, "R2 cnt1 untouched");
    readReg(8'h60, 0, "R2 pre untouched");

    // R9 load bit, R3 control readback
    doCycle(1, 8'h44, 5);
    doCycle(1, 8'h48, 6);
    readReg(8'h40, 5, "R9 load copies reload");
    readReg(8'h48, 2, "R3 load bit reads 0");
    doCycle(1, 8'h44, 9);
    doCycle(1, 8'h48, 32'hFFFF_FFFA);
    readReg(8'h40, 5, "R9 load bit 0 no effect");
    readReg(8'h48, 2, "R3 only bits 1:0 kept");

    // R1 full-width access
    doCycle(1, 8'h50, 32'hDEAD_BEEF);
    doCycle(1, 8'h54, 32'h1234_5678);
    doCycle(1, 8'h64, 32'hA5A5_A5A5);
    readReg(8'h50, 32'hDEAD_BEEF, "R1 cnt2");
    readReg(8'h54, 32'h1234_5678, "R1 rel2");
    readReg(8'h64, 32'hA5A5_A5A5, "R1 prerel");

    // R4 prescaler hold and tick period, R5 counting
    doCycle(1, 8'h64, 2);
    doCycle(1, 8'h60, 5);
    idle(3);
    readReg(8'h60, 5, "R4 prescaler holds when off");
    doCycle(1, 8'h58, 1);
    idle(1);
    readReg(8'h60, 4, "R4 prescaler counts");
    idle(5);
    readReg(8'h60, 2, "R4 reload at zero");
    readReg(8'h50, 32'hDEAD_BEEE, "R5 one step per tick");
    idle(3);
    readReg(8'h50, 32'hDEAD_BEED, "R5 tick period reload+1");
    readReg(8'h40, 5, "R5 disabled timer holds");
    doCycle(1, 8'h58, 0);

    // R8 stop mode
    doCycle(1, 8'h64, 0);
    doCycle(1, 8'h60, 0);
    doCycle(1, 8'h40, 2);
    doCycle(1, 8'h48, 1);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      idle(1);
      if (irqOut[0]) pulses++;
    end
    chk("R8 single pulse in stop mode", pulses, 1);
    readReg(8'h48, 0, "R8 enable cleared");
    readReg(8'h40, 0, "R8 stays at zero");

    // R7 reload mode, R6 one-clock pulses
    doCycle(1, 8'h44, 3);
    doCycle(1, 8'h40, 0);
    doCycle(1, 8'h48, 3);
    pulses = 0; backToBack = 0;
    for (int k = 0; k < 40; k++) begin
      logic prev;
      prev = irqOut[0];
      idle(1);
      if (irqOut[0]) pulses++;
      if (irqOut[0] && prev) backToBack++;
    end
    chk("R7 periodic pulses", pulses, 10);
    chk("R6 pulse lasts one clock", backToBack, 0);

    // R10 load and counter write beat a tick
    doCycle(1, 8'h44, 7);
    doCycle(1, 8'h48, 7);
    readReg(8'h40, 7, "R10 load beats tick");
    doCycle(1, 8'h40, 20);
    readReg(8'h40, 20, "R10 write beats tick");
    doCycle(1, 8'h48, 0);

    // R6 timer 2 drives bit 1
    doCycle(1, 8'h50, 0);
    doCycle(1, 8'h58, 1);
    idle(1);
    chk("R6 timer2 on bit 1", {30'd0, irqOut}, 32'd2);
    idle(1);
    chk("R6 timer2 pulse ends", {30'd0, irqOut}, 32'd0);
    readReg(8'h58, 0, "R8 timer2 disabled");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 10) < 6) idle(1);
      else begin
        a = addrs[$urandom % 12];
        d = (a == 8'h60 || a == 8'h64) ? ($urandom % 4) : ($urandom % 8);
        if (($urandom % 16) == 0) d = d | 32'hFFFF_FFF8 & ((a[3:0] == 4'h8) ? 32'hFFFF_FFF8 : 32'h0);
        doCycle(1, a, d);
      end
      a = addrs[$urandom % 12];
      readReg(a, modelRead(a), "R1 random readback");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule